// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a physical address by reading a two-level translation table from memory. A client presents the virtual address, the base of the first-level table and a read/write flag. The walker then issues word reads on a single-outstanding memory read port. It finishes with a one-cycle completion pulse. The pulse carries one of three results: the physical address, a translation fault, or a bus error. In every case the pulse also returns the original virtual address and the read/write flag.

The first-level table has one 32-bit word per 1 MB of virtual space. An entry there can be a fault, a 1 MB leaf, or a pointer to a second-level table. A second-level table covers one megabyte with 256 words. Its entries can be a fault, a 64 KB leaf or a 4 KB leaf. A 64 KB leaf is stored as sixteen identical words in consecutive slots. The walker therefore reads the slot picked by the address, with no special handling for the larger size.

Only one walk is in flight at a time. The first-level base is assumed to sit on a 16 KB boundary.

Top module: `ptw_walker`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `busy`, `done` and `mem_req` are low.
- R2: The first read goes to address {`req_base`[31:14], va[31:20], 2'b00}. The low 14 bits of `req_base` have no effect on any read address or result.
- R3: A first-level word with low bits 2'b00 or 2'b11 ends the walk with `done_fault`=1 and `done_pa`=0. No second read is issued.
- R4: A first-level word with low bits 2'b10 ends the walk with `done_pa` = {word[31:20], va[19:0]}. No second read is issued.
- R5: A first-level word with low bits 2'b01 causes exactly one second read, at address {word[31:10], va[19:12], 2'b00}. Word bits [9:2] are ignored.
- R6: A second-level word with low bits 2'b00 ends the walk with `done_fault`=1 and `done_pa`=0.
- R7: A second-level word with low bits 2'b01 gives `done_pa` = {word[31:16], va[15:0]}. All sixteen replicated slots of one 64 KB region therefore translate to the same page.
- R8: A second-level word with bit 1 set (low bits 2'b10 or 2'b11) gives `done_pa` = {word[31:12], va[11:0]}.
- R9: If `mem_err` is high with the accepted response at either level, the walk ends with `done_buserr`=1 and `done_fault`=0. No further read is issued.
- R10: A request is accepted only when `req_valid` is high and `busy` is low. `busy` then stays high until the cycle in which `done` pulses, and `busy` is low in that cycle. `done` lasts exactly one cycle. `req_valid` while busy is ignored.
- R11: With every completion, `done_va` returns the accepted virtual address and `done_write` returns the accepted read/write flag.
- R12: `mem_req` stays high with a stable `mem_addr` until a cycle in which `mem_valid` is high. `mem_req` is never high outside a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | First-level table base (16 KB aligned) |
| req_write | input | 1 | Access direction flag (1 = write) |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_pa | output | 32 | Translated physical address (0 on fault or bus error) |
| done_fault | output | 1 | Translation fault |
| done_buserr | output | 1 | Memory read error during the walk |
| done_va | output | 32 | Virtual address of the finished walk |
| done_write | output | 1 | Direction flag of the finished walk |
| mem_req | output | 1 | Memory word read request, held until answered |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_valid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Read response carries an error |

## Verification
`mem_req` and the first read address become visible one clock edge after the request is accepted. The completion pulse appears on the same edge that samples the final `mem_valid`. A zero-latency memory therefore gives `done` two edges after acceptance for a one-read walk and three edges for a two-read walk, plus any wait cycles the memory inserts. The bench drives inputs and its memory model on falling edges. It waits for `done` with a bounded loop and compares the result fields at that falling edge. On the following falling edge it checks that `done` and `busy` are both low, which confirms the single-cycle pulse and that no stray request was taken.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Outcome class of one decoded table word
  typedef enum logic [1:0] {
    WK_FAULT = 2'd0,
    WK_LEAF  = 2'd1,
    WK_NEXT  = 2'd2
  } walk_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LVL1 = 2'd1,
    ST_LVL2 = 2'd2
  } walk_state_t;

endpackage

// File: rtl/ptw_level_decode.sv
module ptw_level_decode
  import ptw_pkg::*;
#(
  parameter int LEVEL         = 1,
  parameter int ADDR_W        = 32,
  parameter int SECT_SHIFT    = 20,
  parameter int LPAGE_SHIFT   = 16,
  parameter int SPAGE_SHIFT   = 12,
  parameter int L2_BASE_SHIFT = 10
) (
  input  logic [ADDR_W-1:0] desc,
  input  logic [ADDR_W-1:0] va,
  output walk_kind_t        kind,
  output logic [ADDR_W-1:0] out_addr
);

  localparam logic [ADDR_W-1:0] ONES = {ADDR_W{1'b1}};

  generate
    if (LEVEL == 1) begin : g_first
      localparam logic [ADDR_W-1:0] SECT_HI   = ONES << SECT_SHIFT;
      localparam logic [ADDR_W-1:0] L2BASE_HI = ONES << L2_BASE_SHIFT;
      localparam int                IDX_W     = SECT_SHIFT - SPAGE_SHIFT;
      localparam logic [ADDR_W-1:0] IDX_MASK  = ~(ONES << IDX_W);

      always_comb begin
        kind     = WK_FAULT;
        out_addr = '0;
        case (desc[1:0])
          2'b10: begin
            kind     = WK_LEAF;
            out_addr = (desc & SECT_HI) | (va & ~SECT_HI);
          end
          2'b01: begin
            kind     = WK_NEXT;
            out_addr = (desc & L2BASE_HI) | (((va >> SPAGE_SHIFT) & IDX_MASK) << 2);
          end
          default: begin
            kind     = WK_FAULT;
            out_addr = '0;
          end
        endcase
      end
    end else begin : g_second
      localparam logic [ADDR_W-1:0] LPAGE_HI = ONES << LPAGE_SHIFT;
      localparam logic [ADDR_W-1:0] SPAGE_HI = ONES << SPAGE_SHIFT;

      always_comb begin
        kind     = WK_FAULT;
        out_addr = '0;
        if (desc[1]) begin
          kind     = WK_LEAF;
          out_addr = (desc & SPAGE_HI) | (va & ~SPAGE_HI);
        end else if (desc[0]) begin
          kind     = WK_LEAF;
          out_addr = (desc & LPAGE_HI) | (va & ~LPAGE_HI);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int SECT_SHIFT    = 20,
  parameter int L1_BASE_ALIGN = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [ADDR_W-1:0] req_base,
  input  logic              req_write,
  input  logic              mem_valid,
  input  logic              mem_err,
  input  walk_kind_t        l1_kind,
  input  logic [ADDR_W-1:0] l1_addr,
  input  walk_kind_t        l2_kind,
  input  logic [ADDR_W-1:0] l2_addr,
  output logic [ADDR_W-1:0] cur_va,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] done_pa,
  output logic              done_fault,
  output logic              done_buserr,
  output logic [ADDR_W-1:0] done_va,
  output logic              done_write,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr
);

  localparam logic [ADDR_W-1:0] L1_BASE_HI = {ADDR_W{1'b1}} << L1_BASE_ALIGN;

  walk_state_t       st;
  logic              wr_q;
  logic              fin, fin_fault, fin_berr, go_next;
  logic [ADDR_W-1:0] fin_pa;
  logic [ADDR_W-1:0] first_addr;
  walk_kind_t        cur_kind;
  logic [ADDR_W-1:0] cur_addr;

  assign first_addr = (req_base & L1_BASE_HI) | ((req_va >> SECT_SHIFT) << 2);

  always_comb begin
    cur_kind = (st == ST_LVL2) ? l2_kind : l1_kind;
    cur_addr = (st == ST_LVL2) ? l2_addr : l1_addr;
  end

  always_comb begin
    fin       = 1'b0;
    fin_pa    = '0;
    fin_fault = 1'b0;
    fin_berr  = 1'b0;
    go_next   = 1'b0;
    if ((st != ST_IDLE) && mem_valid) begin
      if (mem_err) begin
        fin      = 1'b1;
        fin_berr = 1'b1;
      end else begin
        case (cur_kind)
          WK_LEAF: begin
            fin    = 1'b1;
            fin_pa = cur_addr;
          end
          WK_NEXT: begin
            if (st == ST_LVL1) go_next = 1'b1;
            else begin
              fin       = 1'b1;
              fin_fault = 1'b1;
            end
          end
          default: begin
            fin       = 1'b1;
            fin_fault = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cur_va      <= '0;
      wr_q        <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      done_pa     <= '0;
      done_fault  <= 1'b0;
      done_buserr <= 1'b0;
      done_va     <= '0;
      done_write  <= 1'b0;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            st       <= ST_LVL1;
            cur_va   <= req_va;
            wr_q     <= req_write;
            busy     <= 1'b1;
            mem_req  <= 1'b1;
            mem_addr <= first_addr;
          end
        end
        default: begin
          if (go_next) begin
            st       <= ST_LVL2;
            mem_addr <= cur_addr;
          end else if (fin) begin
            st          <= ST_IDLE;
            busy        <= 1'b0;
            mem_req     <= 1'b0;
            done        <= 1'b1;
            done_pa     <= fin_pa;
            done_fault  <= fin_fault;
            done_buserr <= fin_berr;
            done_va     <= cur_va;
            done_write  <= wr_q;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int SECT_SHIFT    = 20,
  parameter int LPAGE_SHIFT   = 16,
  parameter int SPAGE_SHIFT   = 12,
  parameter int L2_BASE_SHIFT = 10,
  parameter int L1_BASE_ALIGN = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [ADDR_W-1:0] req_base,
  input  logic              req_write,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] done_pa,
  output logic              done_fault,
  output logic              done_buserr,
  output logic [ADDR_W-1:0] done_va,
  output logic              done_write,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              mem_err
);

  walk_kind_t        l1_kind, l2_kind;
  logic [ADDR_W-1:0] l1_addr, l2_addr, cur_va;

  ptw_level_decode #(
    .LEVEL(1), .ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .LPAGE_SHIFT(LPAGE_SHIFT),
    .SPAGE_SHIFT(SPAGE_SHIFT), .L2_BASE_SHIFT(L2_BASE_SHIFT)
  ) u_dec1 (
    .desc(mem_rdata), .va(cur_va), .kind(l1_kind), .out_addr(l1_addr)
  );

  ptw_level_decode #(
    .LEVEL(2), .ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .LPAGE_SHIFT(LPAGE_SHIFT),
    .SPAGE_SHIFT(SPAGE_SHIFT), .L2_BASE_SHIFT(L2_BASE_SHIFT)
  ) u_dec2 (
    .desc(mem_rdata), .va(cur_va), .kind(l2_kind), .out_addr(l2_addr)
  );

  ptw_ctrl #(
    .ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .L1_BASE_ALIGN(L1_BASE_ALIGN)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_va(req_va), .req_base(req_base), .req_write(req_write),
    .mem_valid(mem_valid), .mem_err(mem_err),
    .l1_kind(l1_kind), .l1_addr(l1_addr), .l2_kind(l2_kind), .l2_addr(l2_addr),
    .cur_va(cur_va), .busy(busy), .done(done), .done_pa(done_pa),
    .done_fault(done_fault), .done_buserr(done_buserr),
    .done_va(done_va), .done_write(done_write),
    .mem_req(mem_req), .mem_addr(mem_addr)
  );

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              done_fault,
  input logic              done_buserr,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_valid
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !done && !mem_req));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R10
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(req_valid));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R12
  mem_in_walk_chk: assert property (@(posedge clk) disable iff (rst) mem_req |-> busy);

  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !(done_fault && done_buserr));

endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [31:0] req_base = '0;
  logic        req_write = 1'b0;
  logic        busy, done, done_fault, done_buserr, done_write, mem_req;
  logic [31:0] done_pa, done_va, mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_err = 1'b0;

  always #2.5 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va), .req_base(req_base),
    .req_write(req_write), .busy(busy), .done(done), .done_pa(done_pa),
    .done_fault(done_fault), .done_buserr(done_buserr), .done_va(done_va),
    .done_write(done_write), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [31:0] mem_img [logic [31:0]];
  bit          err_map [logic [31:0]];
  int          mem_lat = 0;
  int          wait_cnt = 0;
  int          rd_cnt = 0;
  logic [31:0] rd_a0, rd_a1;
  int          stab_viol = 0;
  bit          holding = 0;
  logic [31:0] hold_addr;

  localparam logic [31:0] TB_BASE = 32'h0040_0000;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_img.exists(a) ? mem_img[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Memory model: answers after mem_lat wait cycles, records read addresses
  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid = 1'b0;
      mem_err   = 1'b0;
      wait_cnt  = 0;
      holding   = 0;
    end else if (mem_req && !rst) begin
      if (!holding) begin
        holding   = 1;
        hold_addr = mem_addr;
      end else if (mem_addr !== hold_addr) stab_viol++;
      if (wait_cnt >= mem_lat) begin
        mem_valid = 1'b1;
        mem_rdata = rd(mem_addr);
        mem_err   = err_map.exists(mem_addr);
        if (rd_cnt == 0) rd_a0 = mem_addr;
        else if (rd_cnt == 1) rd_a1 = mem_addr;
        rd_cnt++;
      end else wait_cnt++;
    end
  end

  // Expected result from the table rules
  task automatic ref_walk(input logic [31:0] va, input logic [31:0] base,
                          output logic [31:0] pa, output bit flt, output bit berr,
                          output int n, output logic [31:0] a0, output logic [31:0] a1);
    logic [31:0] d1, d2;
    a0 = {base[31:14], va[31:20], 2'b00};
    a1 = '0; pa = '0; flt = 0; berr = 0; n = 1;
    d1 = rd(a0);
    if (err_map.exists(a0)) berr = 1;
    else if (d1[1:0] == 2'b10) pa = {d1[31:20], va[19:0]};
    else if (d1[1:0] == 2'b01) begin
      n  = 2;
      a1 = {d1[31:10], va[19:12], 2'b00};
      d2 = rd(a1);
      if (err_map.exists(a1)) berr = 1;
      else if (d2[1]) pa = {d2[31:12], va[11:0]};
      else if (d2[0]) pa = {d2[31:16], va[15:0]};
      else flt = 1;
    end else flt = 1;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input bit wr,
                      input int lat, input bit spam, input string rq);
    logic [31:0] epa, ea0, ea1;
    bit eflt, eberr;
    int en, n;
    ref_walk(va, base, epa, eflt, eberr, en, ea0, ea1);
    mem_lat = lat; rd_cnt = 0; stab_viol = 0;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_base = base; req_write = wr;
    @(negedge clk);
    if (spam) begin
      req_va = ~va; req_write = ~wr;
    end else req_valid = 1'b0;
    chk(busy === 1'b1, "R10", "busy after accept", {31'd0, busy}, 32'd1);
    n = 0;
    while (done !== 1'b1 && n < 200) begin
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk(n < 200, rq, "done timeout", n, 200);
    chk(done_pa === epa, rq, "pa", done_pa, epa);
    chk(done_fault === eflt, rq, "fault (R3/R6)", {31'd0, done_fault}, {31'd0, eflt});
    chk(done_buserr === eberr, rq, "buserr (R9)", {31'd0, done_buserr}, {31'd0, eberr});
    chk(done_va === va, "R11", "done_va", done_va, va);
    chk(done_write === wr, "R11", "done_write", {31'd0, done_write}, {31'd0, wr});
    chk(busy === 1'b0, "R10", "busy with done", {31'd0, busy}, 32'd0);
    chk(rd_cnt == en, rq, "read count", rd_cnt, en);
    chk(rd_a0 === ea0, "R2", "first read addr", rd_a0, ea0);
    if (en == 2) chk(rd_a1 === ea1, "R5", "second read addr", rd_a1, ea1);
    chk(stab_viol == 0, "R12", "addr stable while waiting", stab_viol, 0);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R10", "single pulse, no extra accept",
        {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // Directed table image
    mem_img[TB_BASE + 32'h004] = 32'hABC1_2342;             // 1 MB leaf, middle bits ignored
    mem_img[TB_BASE + 32'h00C] = 32'h1234_5673;             // fault 11
    mem_img[TB_BASE + 32'h010] = 32'h0080_07FD;             // table 0x0080_0400, bits 9:2 junk
    for (int s = 16; s < 32; s++) mem_img[32'h0080_0400 + s*4] = 32'h5555_ABC1;
    mem_img[32'h0080_0400 + 32*4] = 32'h7777_7FFE;          // small 10
    mem_img[32'h0080_0400 + 33*4] = 32'h8888_8003;          // small 11
    mem_img[32'h0080_0400 + 34*4] = 32'hFFFF_FFFC;          // fault 00
    err_map[TB_BASE + 32'h014] = 1;                         // L1 read error
    mem_img[TB_BASE + 32'h018] = 32'h0080_0801;
    err_map[32'h0080_0800] = 1;                             // L2 read error

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1", "busy in reset", {31'd0, busy}, 32'd0);
    chk(done === 1'b0, "R1", "done in reset", {31'd0, done}, 32'd0);
    chk(mem_req === 1'b0, "R1", "mem_req in reset", {31'd0, mem_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && mem_req === 1'b0, "R1", "idle after reset", {30'd0, busy, mem_req}, 32'd0);

    walk(32'h0013_4567, TB_BASE, 1'b0, 0, 1'b0, "R4");
    walk(32'h001F_FFFF, TB_BASE | 32'h3FFF, 1'b1, 2, 1'b0, "R2");
    walk(32'h0020_1000, TB_BASE, 1'b0, 0, 1'b0, "R3");
    walk(32'h0030_0ABC, TB_BASE, 1'b1, 1, 1'b0, "R3");
    for (int s = 16; s < 32; s++)
      walk({12'h004, s[7:0], 12'h000} | ($urandom & 32'hFFF), TB_BASE, 1'b0, s % 3, 1'b0, "R7");
    walk(32'h0042_0123, TB_BASE, 1'b0, 0, 1'b0, "R8");
    walk(32'h0042_1FED, TB_BASE, 1'b1, 0, 1'b0, "R8");
    walk(32'h0042_2000, TB_BASE, 1'b0, 0, 1'b0, "R6");
    walk(32'h0044_4444, TB_BASE, 1'b0, 0, 1'b0, "R5");
    walk(32'h0050_0000, TB_BASE, 1'b0, 1, 1'b0, "R9");
    walk(32'h0060_0FFF, TB_BASE, 1'b1, 0, 1'b0, "R9");
    walk(32'h0042_0456, TB_BASE, 1'b1, 3, 1'b1, "R10");
    walk(32'h0015_5555, TB_BASE, 1'b0, 4, 1'b0, "R12");

    // Random table region
    for (int i = 0; i < 32; i++) begin
      logic [31:0] a, t, d;
      int k;
      a = TB_BASE + (32'h100 + i) * 4;
      k = $urandom % 5;
      if (k == 0) mem_img[a] = 32'h0;
      else if (k == 1) mem_img[a] = $urandom | 32'h3;
      else if (k == 2) mem_img[a] = ($urandom & ~32'h3) | 32'h2;
      else begin
        t = 32'h0090_0000 + i * 32'h400;
        mem_img[a] = t | ($urandom & 32'h3FC) | 32'h1;
        for (int g = 0; g < 16; g++) begin
          if ($urandom % 3 == 0) begin
            d = ($urandom & ~32'h3) | 32'h1;
            for (int s = 0; s < 16; s++) mem_img[t + (g*16 + s)*4] = d;
          end else
            for (int s = 0; s < 16; s++) mem_img[t + (g*16 + s)*4] = $urandom;
          if ($urandom % 20 == 0) err_map[t + g*64] = 1;
        end
      end
      if ($urandom % 25 == 0) err_map[a] = 1;
    end
    for (int r = 0; r < 400; r++) begin
      logic [31:0] idx, va;
      idx = 32'h100 + ($urandom % 40);
      va  = (idx << 20) | ($urandom & 32'hFFFFF);
      walk(va, TB_BASE | ($urandom & 32'h3FFF), $urandom % 2, $urandom % 4, 1'b0, "RND");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule